// File: doc/BRIEF.md
# I2C Byte-Paced Master Controller

This block is a single-master I2C controller that a host steers one byte at a time through a small register window. The host loads a target address byte (7-bit address in bits 7:1, direction in bit 0), then writes the control register with the start request and the master enable bits set. The controller issues START and shifts out the address byte. After each byte it parks the bus with SCL held low and raises status flags. The host releases the next byte by writing zero to the matching status flag. Status flags are cleared only by writing zero to them. A force-stop control bit ends the transfer: while waiting after a written byte it produces STOP at once. When set before the last read byte, it makes the controller NACK that byte and then produce STOP.

The bit clock comes from a prescaler, which divides the system clock by CDF+1, and a phase timer. One SCL period is 20 + 8·SCGD + R prescaled cycles. R is a configuration input that compensates for rise, fall and internal delays. SCL low and high each last half of that sum, rounded down. SDA moves only while SCL is low. The open-drain lines are modelled as pull-low outputs plus input pins. A software override hands both lines directly to two control bits.

The engine has these states: IDLE, START, BIT_LO, BIT_HI, ACK_LO, ACK_HI, WAIT, STOP_LO, STOP_HI and STOP_END.
- IDLE goes to START on a control write that carries both the start-request bit and the enable bit.
- START, BIT_LO, ACK_LO, STOP_LO, STOP_HI and STOP_END each last one half period, then step forward.
- BIT_HI returns to BIT_LO until eight bits are done, then goes to ACK_LO. It drops to IDLE on arbitration loss.
- ACK_HI goes to WAIT. On a read with force-stop it goes to STOP_LO instead.
- WAIT goes to BIT_LO on a release. It goes to STOP_LO on force-stop, which is honoured for writes and after a NACK.
- STOP_END goes to IDLE and sets the STOP flag.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads zero, both pull outputs are low (lines released) and irq is low.
- R2: Writing the status register (offset 0x0C) clears each flag whose written bit is 0 and leaves flags whose written bit is 1. Bit 7 and above always read 0.
- R3: With SCL free-running inside a byte, consecutive SCL rising edges are 2·floor((20+8·SCGD+R)/2)·(CDF+1) system clocks apart. For example, this is 20 clocks for CDF=0, SCGD=0, R=0 and 64 clocks for CDF=1, SCGD=1, R=4.
- R4: A control write (offset 0x04) with bit 0 (start) and bit 3 (enable) set, while idle, issues START and sends the address register byte MSB first. After the acknowledge, status bit 0 is set. A write (direction bit 0) also sets bits 2 and 3, giving 0x0D; a read gives 0x01.
- R5: In a write, a status write with bit 3 at 0 during WAIT sends the data register (offset 0x24) MSB first. After an ACK it sets bits 3 and 2 (0x0C).
- R6: In a read, a status write with bit 1 at 0 during WAIT clocks in one byte, sets bit 1, and makes the byte readable at offset 0x24.
- R7: A read released while control bit 1 (force-stop) is set NACKs that byte, then issues STOP and sets bit 4, giving 0x12 from a cleared status.
- R8: In a write, setting control bit 1 during WAIT issues STOP, sets bit 4, and leaves both lines released.
- R9: A NACK on the address sets bits 6 and 0 together (0x41). The controller then holds SCL low, ignores status-write releases, and only issues STOP once force-stop is set.
- R10: If SDA reads low at the end of an SCL high phase in which the controller released it during address or write data, status bit 5 is set and both lines are released.
- R11: With control bit 4 set, the SCL pull output is the inverse of control bit 6 and the SDA pull output is the inverse of control bit 5.
- R12: irq is high exactly when some status bit and the same bit of the interrupt-enable register (offset 0x14, 7 bits) are both 1.
- R13: Registers read back what was written, masked to their widths: control 8 bits, interrupt enable 7 bits, clock divider (offset 0x18) 9 bits with CDF in bits 2:0 and SCGD in bits 8:3, address (offset 0x20) 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| round_adj | input | 6 | Rise/fall/delay compensation term R |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after these corner cases:
- An address NACK: a design that still honoured releases there would clock a data byte to a target that is absent.
- A final read byte with force-stop pending: getting this wrong leaves the target driving SDA into the STOP, or acknowledges a byte that should end the transfer.
- Two divider settings, measured edge to edge: these catch off-by-one errors in the prescaler and phase timer.
- An SDA line held low by another driver while the controller sends a 1: a design without arbitration detection would keep clocking and corrupt the bus.

// File: rtl/ibm_pkg.sv
package ibm_pkg;
    localparam int CDF_W  = 3;
    localparam int SCGD_W = 6;
    localparam int RND_W  = 6;
    localparam int NFLAG  = 7;
    localparam int HALF_W = $clog2(20 + 8 * ((1 << SCGD_W) - 1) + (1 << RND_W));

    localparam logic [7:0] OFS_CTRL = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_CDIV = 8'h18;
    localparam logic [7:0] OFS_TADR = 8'h20;
    localparam logic [7:0] OFS_DATA = 8'h24;

    localparam int C_START = 0;
    localparam int C_FSTOP = 1;
    localparam int C_EN    = 3;
    localparam int C_OVR   = 4;
    localparam int C_SDA   = 5;
    localparam int C_SCL   = 6;

    localparam int F_ADDR   = 0;
    localparam int F_RXRDY  = 1;
    localparam int F_TXREQ  = 2;
    localparam int F_TXDONE = 3;
    localparam int F_STOP   = 4;
    localparam int F_ARBL   = 5;
    localparam int F_NACK   = 6;

    typedef enum logic [3:0] {
        E_IDLE, E_START, E_BIT_LO, E_BIT_HI, E_ACK_LO, E_ACK_HI,
        E_WAIT, E_STOP_LO, E_STOP_HI, E_STOP_END
    } eng_state_t;
endpackage

// File: rtl/ibm_regs.sv
module ibm_regs
    import ibm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NFLAG-1:0]  set_i,
    input  logic [7:0]        rxd_i,
    output logic [7:0]        ctrl_o,
    output logic [CDF_W-1:0]  cdf_o,
    output logic [SCGD_W-1:0] scgd_o,
    output logic [7:0]        tadr_o,
    output logic [7:0]        txd_o,
    output logic              start_o,
    output logic              rel_rx_o,
    output logic              rel_tx_o,
    output logic              irq_o
);
    localparam int CDIV_W = CDF_W + SCGD_W;

    logic [NFLAG-1:0]  status;
    logic [NFLAG-1:0]  ien;
    logic [CDIV_W-1:0] cdiv;
    logic              st_we;

    assign st_we = we && (addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            ien    <= '0;
            cdiv   <= '0;
            tadr_o <= '0;
            txd_o  <= '0;
        end else if (we) begin
            unique case (addr)
                OFS_CTRL: ctrl_o <= wdata[7:0];
                OFS_IEN:  ien    <= wdata[NFLAG-1:0];
                OFS_CDIV: cdiv   <= wdata[CDIV_W-1:0];
                OFS_TADR: tadr_o <= wdata[7:0];
                OFS_DATA: txd_o  <= wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (st_we ? (status & wdata[NFLAG-1:0]) : status) | set_i;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: rdata[7:0]        = ctrl_o;
            OFS_STAT: rdata[NFLAG-1:0]  = status;
            OFS_IEN:  rdata[NFLAG-1:0]  = ien;
            OFS_CDIV: rdata[CDIV_W-1:0] = cdiv;
            OFS_TADR: rdata[7:0]        = tadr_o;
            OFS_DATA: rdata[7:0]        = rxd_i;
            default:  rdata             = '0;
        endcase
    end

    assign cdf_o    = cdiv[CDF_W-1:0];
    assign scgd_o   = cdiv[CDIV_W-1:CDF_W];
    assign start_o  = we && (addr == OFS_CTRL) && wdata[C_START] && wdata[C_EN];
    assign rel_rx_o = st_we && !wdata[F_RXRDY];
    assign rel_tx_o = st_we && !wdata[F_TXDONE];
    assign irq_o    = |(status & ien);

    // R2
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(set_i)) == '0));
endmodule

// File: rtl/ibm_clkgen.sv
module ibm_clkgen
    import ibm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CDF_W-1:0]  cdf,
    input  logic [SCGD_W-1:0] scgd,
    input  logic [RND_W-1:0]  rnd,
    output logic              phase_tick
);
    logic [HALF_W:0]    full_len;
    logic [HALF_W-1:0]  half_len;
    logic [CDF_W-1:0]   pre_cnt;
    logic [HALF_W-1:0]  half_cnt;
    logic               pre_tick;

    assign full_len   = (HALF_W+1)'(20) + (HALF_W+1)'({scgd, 3'b000}) + (HALF_W+1)'(rnd);
    assign half_len   = full_len[HALF_W:1];
    assign pre_tick   = run && (pre_cnt == cdf);
    assign phase_tick = pre_tick && (half_cnt >= half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            half_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            half_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt  <= '0;
            half_cnt <= phase_tick ? '0 : half_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ibm_engine.sv
module ibm_engine
    import ibm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_tick,
    output logic             run_o,
    input  logic             start_i,
    input  logic             rel_rx_i,
    input  logic             rel_tx_i,
    input  logic             fstop_i,
    input  logic [7:0]       tadr_i,
    input  logic [7:0]       txd_i,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic [NFLAG-1:0] set_o,
    output logic [7:0]       rxd_o
);
    eng_state_t st, nx;
    logic [7:0] sh;
    logic [2:0] bcnt;
    logic       rd, is_addr, nhold, last_rx;
    logic       tx_mode, lost, go;

    assign tx_mode = is_addr || !rd;
    assign lost    = tx_mode && sh[7] && !sda_in;
    assign go      = !nhold && (rd ? rel_rx_i : rel_tx_i);
    assign run_o   = (st != E_IDLE) && (st != E_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            E_IDLE:     if (start_i) nx = E_START;
            E_START:    if (phase_tick) nx = E_BIT_LO;
            E_BIT_LO:   if (phase_tick) nx = E_BIT_HI;
            E_BIT_HI:   if (phase_tick) nx = lost ? E_IDLE : ((bcnt == 3'd7) ? E_ACK_LO : E_BIT_LO);
            E_ACK_LO:   if (phase_tick) nx = E_ACK_HI;
            E_ACK_HI:   if (phase_tick) nx = (!tx_mode && last_rx) ? E_STOP_LO : E_WAIT;
            E_WAIT: begin
                if ((!rd || nhold) && fstop_i) nx = E_STOP_LO;
                else if (go)                   nx = E_BIT_LO;
            end
            E_STOP_LO:  if (phase_tick) nx = E_STOP_HI;
            E_STOP_HI:  if (phase_tick) nx = E_STOP_END;
            E_STOP_END: if (phase_tick) nx = E_IDLE;
            default:    nx = E_IDLE;
        endcase
    end

    always_comb begin
        scl_pull_o = 1'b0;
        sda_pull_o = 1'b0;
        unique case (st)
            E_START:   sda_pull_o = 1'b1;
            E_BIT_LO: begin scl_pull_o = 1'b1; sda_pull_o = tx_mode && !sh[7]; end
            E_BIT_HI:  sda_pull_o = tx_mode && !sh[7];
            E_ACK_LO: begin scl_pull_o = 1'b1; sda_pull_o = !tx_mode && !last_rx; end
            E_ACK_HI:  sda_pull_o = !tx_mode && !last_rx;
            E_WAIT:    scl_pull_o = 1'b1;
            E_STOP_LO: begin scl_pull_o = 1'b1; sda_pull_o = 1'b1; end
            E_STOP_HI: sda_pull_o = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        set_o = '0;
        if (phase_tick) begin
            if (st == E_BIT_HI && lost) set_o[F_ARBL] = 1'b1;
            if (st == E_STOP_END)       set_o[F_STOP] = 1'b1;
            if (st == E_ACK_HI) begin
                if (is_addr) set_o[F_ADDR] = 1'b1;
                if (tx_mode && sda_in) set_o[F_NACK] = 1'b1;
                if (!rd && !sda_in) begin
                    set_o[F_TXDONE] = 1'b1;
                    set_o[F_TXREQ]  = 1'b1;
                end
                if (!is_addr && !rd) begin
                    set_o[F_TXDONE] = 1'b1;
                    set_o[F_TXREQ]  = 1'b1;
                end
                if (!tx_mode) set_o[F_RXRDY] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; bcnt <= '0; rd <= 1'b0; is_addr <= 1'b0;
            nhold <= 1'b0; last_rx <= 1'b0; rxd_o <= '0;
        end else begin
            unique case (st)
                E_IDLE: if (start_i) begin
                    sh <= tadr_i; rd <= tadr_i[0]; is_addr <= 1'b1;
                    bcnt <= '0; nhold <= 1'b0; last_rx <= 1'b0;
                end
                E_BIT_HI: if (phase_tick && !lost) begin
                    sh   <= {sh[6:0], sda_in};
                    bcnt <= bcnt + 1'b1;
                end
                E_ACK_HI: if (phase_tick) begin
                    if (tx_mode && sda_in) nhold <= 1'b1;
                    if (!tx_mode) rxd_o <= sh;
                end
                E_WAIT: if (nx == E_BIT_LO) begin
                    is_addr <= 1'b0;
                    bcnt    <= '0;
                    if (rd) last_rx <= fstop_i;
                    else    sh      <= txd_i;
                end
                E_STOP_END: if (phase_tick) nhold <= 1'b0;
                default: ;
            endcase
        end
    end

    // R3
    bit_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_BIT_LO && !phase_tick) |=> (st == E_BIT_LO));
    // R4
    sda_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_BIT_HI && $past(st) == E_BIT_HI) |-> $stable(sda_pull_o));
    // R10
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[F_ARBL] |=> (!scl_pull_o && !sda_pull_o));
    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[F_STOP] |=> (st == E_IDLE));
    // R9
    nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_WAIT && nhold && !fstop_i) |=> (st == E_WAIT));
    // R8
    wait_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_WAIT) |-> (scl_pull_o && !scl_in == scl_pull_o));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import ibm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [RND_W-1:0] round_adj,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             irq
);
    logic [7:0]        ctrl, tadr, txd, rxd;
    logic [CDF_W-1:0]  cdf;
    logic [SCGD_W-1:0] scgd;
    logic [NFLAG-1:0]  set_flags;
    logic              start_p, rel_rx, rel_tx, run, phase_tick;
    logic              eng_scl, eng_sda;

    ibm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .set_i(set_flags), .rxd_i(rxd),
        .ctrl_o(ctrl), .cdf_o(cdf), .scgd_o(scgd), .tadr_o(tadr), .txd_o(txd),
        .start_o(start_p), .rel_rx_o(rel_rx), .rel_tx_o(rel_tx), .irq_o(irq)
    );

    ibm_clkgen u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .cdf(cdf), .scgd(scgd),
        .rnd(round_adj), .phase_tick(phase_tick)
    );

    ibm_engine u_engine (
        .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .run_o(run),
        .start_i(start_p), .rel_rx_i(rel_rx), .rel_tx_i(rel_tx),
        .fstop_i(ctrl[C_FSTOP]), .tadr_i(tadr), .txd_i(txd),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_o(eng_scl), .sda_pull_o(eng_sda), .set_o(set_flags), .rxd_o(rxd)
    );

    assign scl_pull = ctrl[C_OVR] ? !ctrl[C_SCL] : eng_scl;
    assign sda_pull = ctrl[C_OVR] ? !ctrl[C_SDA] : eng_sda;

    // R11
    ovr_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[C_OVR] |-> (scl_pull != ctrl[C_SCL] && sda_pull != ctrl[C_SDA]));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  round_adj = '0;
    logic        scl_pull, sda_pull, irq;
    logic        s_drive = 1'b0;
    logic        ext_sda_low = 1'b0;
    wire         scl_bus = !scl_pull;
    wire         sda_bus = !(sda_pull || s_drive || ext_sda_low);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    i2c_byte_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .round_adj(round_adj),
        .scl_in(scl_bus), .sda_in(sda_bus), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .irq(irq)
    );

    always #4 clk = !clk;

    // behavioural target on the bus, sampled away from the active edge
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic       s_active = 1'b0, s_is_addr = 1'b0, s_rd = 1'b0;
    logic       s_addr_ack = 1'b1, s_data_ack = 1'b1, s_mack = 1'b0;
    logic [7:0] s_sr = '0, s_addr_byte = '0, s_rx_byte = '0, s_tx_byte = '0;
    int         s_rc = 0, s_stops = 0, cyc = 0, last_rise = 0, gap = 0;

    always @(negedge clk) begin
        cyc++;
        if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
            s_active = 1'b1; s_is_addr = 1'b1; s_rc = 0; s_drive = 1'b0;
        end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
            s_stops++; s_active = 1'b0; s_drive = 1'b0;
        end else if (scl_bus && !prev_scl) begin
            gap = cyc - last_rise; last_rise = cyc;
            if (s_active) begin
                if (s_rc < 8) s_sr = {s_sr[6:0], sda_bus};
                else if (s_rd && !s_is_addr) begin
                    s_mack = !sda_bus;
                    if (sda_bus) s_active = 1'b0;
                end
                s_rc++;
            end
        end else if (!scl_bus && prev_scl && s_active) begin
            if (s_rc == 8) begin
                if (s_is_addr) begin
                    s_addr_byte = s_sr; s_rd = s_sr[0];
                    s_drive = s_addr_ack;
                    if (!s_addr_ack) s_active = 1'b0;
                end else if (!s_rd) begin
                    s_rx_byte = s_sr; s_drive = s_data_ack;
                end else s_drive = 1'b0;
            end else if (s_rc == 9) begin
                s_rc = 0; s_is_addr = 1'b0;
                s_drive = s_rd ? !s_tx_byte[7] : 1'b0;
            end else if (s_rd && !s_is_addr) s_drive = !s_tx_byte[7 - s_rc];
        end
        if (!s_active && !(s_rc == 8 && s_drive)) s_drive = s_drive && s_active;
        prev_scl = scl_bus; prev_sda = sda_bus;
    end

    // {rd, addr7, byte, data_ack}
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 7'h50, 8'hA5, 1'b1},
        {1'b0, 7'h2B, 8'h00, 1'b1},
        {1'b0, 7'h7F, 8'hFF, 1'b0},
        {1'b1, 7'h50, 8'h3C, 1'b1},
        {1'b1, 7'h11, 8'h81, 1'b1},
        {1'b1, 7'h6A, 8'hFF, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic wait_flag(input int bitn, input string req);
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(8'h0C, v);
            if (v[bitn]) return;
        end
        chk(req, 0, 32'(1) << bitn);
    endtask

    logic [31:0] v;
    int stops0;

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 scl_pull", 32'(scl_pull), 0);
        chk("R1 sda_pull", 32'(sda_pull), 0);
        chk("R1 irq", 32'(irq), 0);
        foreach (VEC[i]) ;
        rd_reg(8'h04, v); chk("R1 ctrl", v, 0);
        rd_reg(8'h0C, v); chk("R1 status", v, 0);
        rd_reg(8'h14, v); chk("R1 ien", v, 0);
        rd_reg(8'h18, v); chk("R1 cdiv", v, 0);
        rd_reg(8'h20, v); chk("R1 tadr", v, 0);
        rd_reg(8'h24, v); chk("R1 data", v, 0);

        // R13 readback masks
        wr(8'h18, 32'hFFFF_FFFF); rd_reg(8'h18, v); chk("R13 cdiv", v, 32'h1FF);
        wr(8'h14, 32'hFFFF_FFFF); rd_reg(8'h14, v); chk("R13 ien", v, 32'h7F);
        wr(8'h20, 32'hFFFF_FFFF); rd_reg(8'h20, v); chk("R13 tadr", v, 32'hFF);
        wr(8'h04, 32'h0000_00A6); rd_reg(8'h04, v); chk("R13 ctrl", v, 32'hA6);
        wr(8'h18, 0); wr(8'h14, 0); wr(8'h04, 32'h80);

        // table of transactions: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 6; i++) begin
            logic rdm; logic [6:0] a7; logic [7:0] b; logic ak;
            {rdm, a7, b, ak} = VEC[i];
            s_data_ack = ak; s_tx_byte = b;
            wr(8'h0C, 0); wr(8'h04, 32'h80);
            wr(8'h20, {24'h0, a7, rdm});
            stops0 = s_stops;
            wr(8'h04, 32'h89);
            wait_flag(0, "R4 addr done");
            rd_reg(8'h0C, v); chk("R4 status after address", v, rdm ? 32'h01 : 32'h0D);
            chk("R4 address byte on bus", 32'(s_addr_byte), {24'h0, a7, rdm});
            chk("R3 scl period cfg0", 32'(gap), 20);
            if (!rdm) begin
                wr(8'h24, {24'h0, b});
                wr(8'h0C, 0);
                wait_flag(3, "R5 byte sent");
                rd_reg(8'h0C, v); chk("R5 status after data", v, ak ? 32'h0C : 32'h4C);
                chk("R5 target got byte", 32'(s_rx_byte), 32'(b));
                wr(8'h04, 32'h8A);
                wait_flag(4, "R8 stop");
                rd_reg(8'h0C, v); chk("R8 status after stop", v, ak ? 32'h1C : 32'h5C);
                chk("R8 stop on bus", 32'(s_stops - stops0), 1);
                chk("R8 lines released", 32'({scl_pull, sda_pull}), 0);
            end else begin
                wr(8'h04, 32'h8A);
                wr(8'h0C, 0);
                wait_flag(4, "R7 stop");
                rd_reg(8'h0C, v); chk("R7 status after last read", v, 32'h12);
                rd_reg(8'h24, v); chk("R6 received byte", v, 32'(b));
                chk("R7 master NACKed last byte", 32'(s_mack), 0);
                chk("R7 stop on bus", 32'(s_stops - stops0), 1);
            end
        end

        // R12 interrupt gating (status now 0x12)
        wr(8'h14, 32'h10); @(negedge clk); chk("R12 irq enabled", 32'(irq), 1);
        wr(8'h14, 32'h01); @(negedge clk); chk("R12 irq masked", 32'(irq), 0);
        wr(8'h14, 0);

        // R2 write-zero-to-clear
        wr(8'h0C, 32'hFFFF_FFFF); rd_reg(8'h0C, v); chk("R2 ones keep", v, 32'h12);
        wr(8'h0C, 32'hFFFF_FFEF); rd_reg(8'h0C, v); chk("R2 clear one bit", v, 32'h02);
        wr(8'h0C, 0); rd_reg(8'h0C, v); chk("R2 clear all", v, 0);

        // R9 address NACK
        s_addr_ack = 1'b0;
        wr(8'h04, 32'h80); wr(8'h20, 32'h66);
        stops0 = s_stops;
        wr(8'h04, 32'h89);
        wait_flag(0, "R9 addr done");
        rd_reg(8'h0C, v); chk("R9 status nack", v, 32'h41);
        repeat (100) @(negedge clk);
        wr(8'h0C, 0);
        repeat (300) @(negedge clk);
        chk("R9 scl held low", 32'(scl_pull), 1);
        rd_reg(8'h0C, v); chk("R9 release ignored", v, 0);
        chk("R9 no stop yet", 32'(s_stops - stops0), 0);
        wr(8'h04, 32'h8A);
        wait_flag(4, "R9 stop");
        rd_reg(8'h0C, v); chk("R9 stop after force", v, 32'h10);
        s_addr_ack = 1'b1;

        // R3 second divider setting
        round_adj = 6'd4;
        wr(8'h18, 32'h09); wr(8'h0C, 0); wr(8'h04, 32'h80);
        wr(8'h20, 32'hA0);
        wr(8'h04, 32'h89);
        wait_flag(0, "R3 addr done cfg1");
        chk("R3 scl period cfg1", 32'(gap), 64);
        wr(8'h04, 32'h8A);
        wait_flag(4, "R3 stop cfg1");
        round_adj = 6'd0; wr(8'h18, 0);

        // R10 arbitration loss on a released 1 bit
        wr(8'h0C, 0); wr(8'h04, 32'h80); wr(8'h20, 32'h80);
        wr(8'h04, 32'h89);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!scl_bus) break;
        end
        ext_sda_low = 1'b1;
        wait_flag(5, "R10 arbitration");
        rd_reg(8'h0C, v); chk("R10 status arb lost", v, 32'h20);
        chk("R10 lines released", 32'({scl_pull, sda_pull}), 0);
        ext_sda_low = 1'b0;
        repeat (5) @(negedge clk);

        // R11 software override
        wr(8'h04, 32'h10); chk("R11 both low", 32'({scl_pull, sda_pull}), 32'h3);
        wr(8'h04, 32'h70); chk("R11 both released", 32'({scl_pull, sda_pull}), 32'h0);
        wr(8'h04, 32'h50); chk("R11 sda low only", 32'({scl_pull, sda_pull}), 32'h1);
        wr(8'h04, 32'h70); wr(8'h04, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule